// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block latches interrupt events from two groups of sources and turns them into one level-sensitive interrupt line. The first group has eight local-side event sources, held in a local status byte. The second group has four bridge-side error flags, held in a 16-bit error status word. Upstream logic detects the events and delivers each one as a single-cycle pulse. Here the pulse sets a sticky bit, which stays set until software clears it.

Software reaches four registers through a small port. A write uses a strobe, a two-bit address and a data word. A read is combinational on the address and has no side effects. The two status registers clear in different ways. In the local byte, every bit written as zero is cleared, so writing 0x00 clears all pending events. In the error word, every bit written as one is cleared, so writing back the value just read clears exactly the errors that were seen.

Local events only reach the interrupt line through a per-bit mask and a global enable bit in a control register. Error flags drive the line directly.

Top module: `irq_stat_unit`

## Requirements
- R1: A pulse on `lcl_evt[i]` sets bit i of the local status byte (address 0), and the bit holds until cleared. Bit meanings: 7 mailbox, 6 read abort, 5 write abort, 4 external pin interrupt, 3 bus parity error, 2 inbound queue post, 1 DMA channel 1 done, 0 DMA channel 0 done.
- R2: A pulse on `perr_evt` sets a sticky bit in the error status word (address 2): `perr_evt[3]` sets bit 15 (parity), [2] sets bit 14 (system error), [1] sets bit 13 (master abort), [0] sets bit 12 (target abort). Bits 11:0 read as zero.
- R3: A write to address 0 clears each local status bit whose data bit is 0 and leaves bits written as 1 unchanged. Writing 0x00 clears all of them.
- R4: A write to address 2 clears each error bit whose data bit (15:12) is 1 and leaves the others unchanged. Writing back the value just read clears exactly the bits that were set.
- R5: An event pulse that arrives in the same cycle as a write that clears its bit wins, and the bit stays set.
- R6: The mask register (address 1, bits 7:0, same layout as the local byte) reads back what was written. Only local status bits whose mask bit is 1 can raise `irq_o`.
- R7: Bit 0 of the control register (address 3) is the local interrupt enable. While it is 0, no local status bit can raise `irq_o`.
- R8: With the default combinational output, `irq_o` is high when (enable AND any masked local bit is set) OR any error bit is set. It follows the registers in the same cycle in which they change.
- R9: After reset, all status, mask and enable registers are zero and `irq_o` is low.
- R10: `reg_rdata` shows the addressed register. Bits that register does not define read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcl_evt | input | 8 | Local event pulses, one per status bit |
| perr_evt | input | 4 | Error flag pulses (3 parity, 2 system, 1 master abort, 0 target abort) |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 local status, 1 mask, 2 error status, 3 control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt output |

## Verification
On every cycle, the assertions check four things:
- an event pulse sets its status bit, including when a clearing write lands in the same cycle;
- the clear-on-zero and clear-on-one rules for the two status registers;
- any error bit drives the interrupt;
- a cleared enable or an all-zero mask keeps local status from reaching the line.

Only the bench scenarios can show the rest: the exact bit positions seen through the read port, the reset values, mask read-back, and the order in which sources raise and drop the interrupt as masks and the enable change.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   typedef enum logic [1:0] {
      REG_LSTAT = 2'd0,
      REG_LMASK = 2'd1,
      REG_PSTAT = 2'd2,
      REG_CTRL  = 2'd3
   } reg_sel_e;

   // How a register write removes pending bits
   typedef enum logic {
      CLR_ON_ZERO = 1'b0,
      CLR_ON_ONE  = 1'b1
   } clr_mode_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
   import irq_stat_pkg::*;
#(
   parameter int        W        = 8,
   parameter clr_mode_e CLR_MODE = CLR_ON_ONE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] stat_o
);

   logic [W-1:0] clr_w;
   logic [W-1:0] stat_q;

   generate
      if (CLR_MODE == CLR_ON_ZERO) begin : g_clr_zero
         assign clr_w = wr_i ? ~wdata_i : '0;
      end else begin : g_clr_one
         assign clr_w = wr_i ? wdata_i : '0;
      end
   endgenerate

   // A new event has priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_w) | evt_i;
   end

   assign stat_o = stat_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mask_wr_i,
   input  logic         ctrl_wr_i,
   input  logic [W-1:0] mask_wdata_i,
   input  logic         en_wdata_i,
   output logic [W-1:0] mask_o,
   output logic         en_o
);

   logic [W-1:0] mask_q;
   logic         en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b0;
      end else begin
         if (mask_wr_i) mask_q <= mask_wdata_i;
         if (ctrl_wr_i) en_q   <= en_wdata_i;
      end
   end

   assign mask_o = mask_q;
   assign en_o   = en_q;

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int LW      = 8,
   parameter int PW      = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] lstat_i,
   input  logic [LW-1:0] mask_i,
   input  logic          en_i,
   input  logic [PW-1:0] pstat_i,
   output logic          irq_o
);

   logic lcl_req_w;
   logic irq_c;

   assign lcl_req_w = en_i & (|(lstat_i & mask_i));
   assign irq_c     = lcl_req_w | (|pstat_i);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         logic clk_unused;
         assign clk_unused = clk ^ rst_n;
         assign irq_o = irq_c;
      end
   endgenerate

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
   import irq_stat_pkg::*;
#(
   parameter int LCL_W    = 8,
   parameter int PERR_W   = 4,
   parameter int PERR_LSB = 12,
   parameter int DATA_W   = 16,
   parameter bit REG_IRQ  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LCL_W-1:0]  lcl_evt,
   input  logic [PERR_W-1:0] perr_evt,
   input  logic              reg_wen,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);

   localparam int PERR_MSB = PERR_LSB + PERR_W - 1;

   generate
      if (PERR_MSB >= DATA_W) begin : g_bad_perr
         $error("irq_stat_unit: error field does not fit the data word");
      end
      if (LCL_W > DATA_W) begin : g_bad_lcl
         $error("irq_stat_unit: local byte wider than the data word");
      end
   endgenerate

   logic [LCL_W-1:0]  lstat_w;
   logic [LCL_W-1:0]  mask_w;
   logic [PERR_W-1:0] pstat_w;
   logic              en_w;
   logic              wr_lstat, wr_pstat, wr_mask, wr_ctrl;
   logic              wdata_unused;

   assign wr_lstat = reg_wen && (reg_addr == REG_LSTAT);
   assign wr_mask  = reg_wen && (reg_addr == REG_LMASK);
   assign wr_pstat = reg_wen && (reg_addr == REG_PSTAT);
   assign wr_ctrl  = reg_wen && (reg_addr == REG_CTRL);
   assign wdata_unused = ^reg_wdata;

   irq_status_bank #(.W(LCL_W), .CLR_MODE(CLR_ON_ZERO)) u_lstat (
      .clk(clk), .rst_n(rst_n), .evt_i(lcl_evt), .wr_i(wr_lstat),
      .wdata_i(reg_wdata[LCL_W-1:0]), .stat_o(lstat_w)
   );

   irq_status_bank #(.W(PERR_W), .CLR_MODE(CLR_ON_ONE)) u_pstat (
      .clk(clk), .rst_n(rst_n), .evt_i(perr_evt), .wr_i(wr_pstat),
      .wdata_i(reg_wdata[PERR_MSB:PERR_LSB]), .stat_o(pstat_w)
   );

   irq_cfg_regs #(.W(LCL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .mask_wr_i(wr_mask), .ctrl_wr_i(wr_ctrl),
      .mask_wdata_i(reg_wdata[LCL_W-1:0]), .en_wdata_i(reg_wdata[0]),
      .mask_o(mask_w), .en_o(en_w)
   );

   irq_combine #(.LW(LCL_W), .PW(PERR_W), .REG_OUT(REG_IRQ)) u_comb (
      .clk(clk), .rst_n(rst_n), .lstat_i(lstat_w), .mask_i(mask_w),
      .en_i(en_w), .pstat_i(pstat_w), .irq_o(irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel_e'(reg_addr))
         REG_LSTAT: reg_rdata[LCL_W-1:0]       = lstat_w;
         REG_LMASK: reg_rdata[LCL_W-1:0]       = mask_w;
         REG_PSTAT: reg_rdata[PERR_MSB:PERR_LSB] = pstat_w;
         REG_CTRL:  reg_rdata[0]               = en_w;
      endcase
   end

endmodule

// File: rtl/irq_stat_unit_chk.sv
module irq_stat_unit_chk
   import irq_stat_pkg::*;
#(
   parameter int LCL_W    = 8,
   parameter int PERR_W   = 4,
   parameter int PERR_LSB = 12,
   parameter int DATA_W   = 16,
   parameter bit REG_IRQ  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LCL_W-1:0]  lcl_evt,
   input logic [PERR_W-1:0] perr_evt,
   input logic              reg_wen,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [LCL_W-1:0]  lstat,
   input logic [PERR_W-1:0] pstat,
   input logic [LCL_W-1:0]  mask,
   input logic              en,
   input logic              irq
);

   localparam int PERR_MSB = PERR_LSB + PERR_W - 1;

   AST_LCL_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (lcl_evt != '0) |=> ((lstat & $past(lcl_evt)) == $past(lcl_evt))); // R1

   AST_PERR_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_evt != '0) |=> ((pstat & $past(perr_evt)) == $past(perr_evt))); // R5

   AST_LCL_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == REG_LSTAT && lcl_evt == '0)
      |=> (lstat == ($past(lstat) & $past(reg_wdata[LCL_W-1:0])))); // R3

   AST_PERR_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == REG_PSTAT && perr_evt == '0)
      |=> (pstat == ($past(pstat) & ~$past(reg_wdata[PERR_MSB:PERR_LSB])))); // R4

   generate
      if (REG_IRQ) begin : g_reg_chk
         AST_PERR_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (pstat != '0) |=> irq); // R8
         AST_EN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (pstat == '0 && !en) |=> !irq); // R7
         AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (pstat == '0 && mask == '0) |=> !irq); // R6
      end else begin : g_comb_chk
         AST_PERR_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (pstat != '0) |-> irq); // R8
         AST_EN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (pstat == '0 && !en) |-> !irq); // R7
         AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (pstat == '0 && mask == '0) |-> !irq); // R6
      end
   endgenerate

endmodule

bind irq_stat_unit irq_stat_unit_chk #(
   .LCL_W(LCL_W), .PERR_W(PERR_W), .PERR_LSB(PERR_LSB),
   .DATA_W(DATA_W), .REG_IRQ(REG_IRQ)
) chk_i (
   .clk(clk), .rst_n(rst_n), .lcl_evt(lcl_evt), .perr_evt(perr_evt),
   .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .lstat(lstat_w), .pstat(pstat_w), .mask(mask_w), .en(en_w), .irq(irq_o)
);

// File: tb/irq_stat_unit_tb.sv
module irq_stat_unit_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  lcl_evt = '0;
   logic [3:0]  perr_evt = '0;
   logic        reg_wen = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_stat_unit dut_i (
      .clk(clk), .rst_n(rst_n), .lcl_evt(lcl_evt), .perr_evt(perr_evt),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   // Monitor: compares queued expectations half a cycle after driving
   always @(negedge clk) begin
      item_t it;
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         checks++;
         if (it.is_irq) begin
            if (irq_o !== it.exp[0]) begin
               failures++;
               $display("FAIL %s irq_o actual=%0b expected=%0b", it.tag, irq_o, it.exp[0]);
            end
         end else if (reg_rdata !== it.exp) begin
            failures++;
            $display("FAIL %s rdata actual=0x%04h expected=0x%04h", it.tag, reg_rdata, it.exp);
         end
      end
   end

   task automatic step(input bit wen, input logic [1:0] a, input logic [15:0] d,
                       input logic [7:0] le, input logic [3:0] pe);
      reg_wen = wen; reg_addr = a; reg_wdata = d; lcl_evt = le; perr_evt = pe;
      @(posedge clk); #1;
      reg_wen = 1'b0; lcl_evt = '0; perr_evt = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      step(1'b1, a, d, '0, '0);
   endtask

   task automatic exp_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
      reg_addr = a;
      sb_q.push_back('{1'b0, e, tag});
      @(posedge clk); #1;
   endtask

   task automatic exp_irq(input bit e, input string tag);
      sb_q.push_back('{1'b1, {15'd0, e}, tag});
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9 reset state
      exp_reg(2'd0, 16'h0000, "R9 lstat");
      exp_reg(2'd1, 16'h0000, "R9 mask");
      exp_reg(2'd2, 16'h0000, "R9 pstat");
      exp_reg(2'd3, 16'h0000, "R9 ctrl");
      exp_irq(1'b0, "R9 irq");
      // R1 sticky local events (bit7 mailbox, bit0 DMA0)
      step(1'b0, 2'd0, 16'h0, 8'h81, 4'h0);
      step(1'b0, 2'd0, 16'h0, 8'h00, 4'h0);
      exp_reg(2'd0, 16'h0081, "R1 lstat");
      exp_irq(1'b0, "R6 mask zero");
      wr(2'd1, 16'h0080);
      exp_reg(2'd1, 16'h0080, "R6 mask readback");
      exp_irq(1'b0, "R7 enable off");
      wr(2'd3, 16'hFFFF);
      exp_reg(2'd3, 16'h0001, "R10 ctrl unused bits");
      exp_irq(1'b1, "R8 masked local");
      // R3 per-bit clear on zero
      wr(2'd0, 16'h00FE);
      exp_reg(2'd0, 16'h0080, "R3 partial clear");
      exp_irq(1'b1, "R8 still pending");
      wr(2'd0, 16'h0000);
      exp_reg(2'd0, 16'h0000, "R3 clear all");
      exp_irq(1'b0, "R8 drops");
      // R5 event beats clear
      step(1'b1, 2'd0, 16'h0000, 8'h10, 4'h0);
      exp_reg(2'd0, 16'h0010, "R5 local event wins");
      wr(2'd0, 16'h0000);
      // R6 mask selects sources
      step(1'b0, 2'd0, 16'h0, 8'h04, 4'h0);
      exp_irq(1'b0, "R6 unmasked bit blocked");
      wr(2'd1, 16'h0084);
      exp_irq(1'b1, "R6 masked bit passes");
      wr(2'd3, 16'h0000);
      exp_irq(1'b0, "R7 enable cleared");
      wr(2'd0, 16'h0000);
      // R2 error word
      step(1'b0, 2'd0, 16'h0, 8'h00, 4'b1010);
      exp_reg(2'd2, 16'hA000, "R2 parity and master abort");
      exp_irq(1'b1, "R8 error ignores enable");
      wr(2'd2, 16'h2000);
      exp_reg(2'd2, 16'h8000, "R4 one bit cleared");
      wr(2'd2, 16'h8000);
      exp_reg(2'd2, 16'h0000, "R4 write back clears");
      exp_irq(1'b0, "R8 error gone");
      step(1'b0, 2'd0, 16'h0, 8'h00, 4'b0101);
      exp_reg(2'd2, 16'h5000, "R2 system and target abort");
      wr(2'd2, 16'h0FFF);
      exp_reg(2'd2, 16'h5000, "R4 low bits no effect");
      step(1'b1, 2'd2, 16'hF000, 8'h00, 4'b0001);
      exp_reg(2'd2, 16'h1000, "R5 error event wins");
      exp_reg(2'd0, 16'h0000, "R10 lstat after error traffic");
      done = 1'b1;
   end

   initial begin
      wait (done);
      @(negedge clk); #1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule